// File: doc/BRIEF.md
# Activity-Driven Clock Gating Controller

This block stops a downstream clock while the logic it feeds has no work in flight. It watches an outstanding-transaction count. When the count has read zero for long enough, the controller moves from its idle state to a gated state and holds the derived clock low. When work shows up again, it returns to idle after a short, programmable wake-up delay and the clock runs again.

Two delay inputs tune the hysteresis. The entry delay sets how many consecutive zero samples of the count are needed before gating. The exit delay sets how many edges pass between the first nonzero sample and ungating. Both are limited to ten cycles.

The enable is captured by a latch that is transparent only while the clock is low. The derived clock therefore only ever carries whole pulses. The latch is fed with the next-state decision, so the clock stops in the same cycle as the gated state code appears and restarts in the same cycle as the idle code returns.

Top module: `act_clk_gate`

## Requirements
- R1: While `rst_n_i` is low at a rising edge, the state after that edge is 0 (idle), `clk_en_o` is 1 and `gclk_o` pulses in the following high phase, whatever the previous state was.
- R2: `state_o` uses code 0 for idle and code 2 for gated, and shows no other value.
- R3: With effective entry delay D, the state changes from 0 to 2 on the (D+1)-th consecutive rising edge at which `txn_cnt_i` is zero. The state stays 0 on the D edges before it.
- R4: Any value above 10 on `entry_dly_i` or `exit_dly_i` behaves as 10.
- R5: In the gated state with effective exit delay E, a rising edge that samples a nonzero count starts the wake-up. The state reads 0 after E further edges, so a delay of 0 ungates on that same edge and a delay of 10 keeps the state at 2 for at most 10 edges after the first nonzero sample.
- R6: Once the wake-up has started, it completes on schedule even if the count returns to zero in the meantime.
- R7: In every clock high phase during which `state_o` is 2, `gclk_o` is low. This includes the first such cycle. The state stays 2 for as long as the count keeps reading zero.
- R8: In every clock high phase during which `state_o` is 0, `gclk_o` is high. In every low phase, `gclk_o` is low.
- R9: `clk_en_o` is 1 exactly when `state_o` is 0.
- R10: The state never changes from 0 to 2 on an edge that samples a nonzero count. A nonzero sample restarts the entry count, so D+1 fresh zero samples are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| txn_cnt_i | input | CNT_W | Outstanding transaction count; zero means no work in flight |
| entry_dly_i | input | DLY_W | Extra consecutive zero samples required before gating (0..10) |
| exit_dly_i | input | DLY_W | Edges from the first nonzero sample to ungating (0..10) |
| gclk_o | output | 1 | Gated clock for the downstream logic |
| state_o | output | 2 | State code: 0 idle, 2 gated |
| clk_en_o | output | 1 | High while the derived clock is running |

## Verification
The bench uses the default parameters: an 8-bit count, 4-bit delay fields and a ceiling of 10. With 4-bit delay fields, the out-of-range values 13 and 15 can be driven, so the clamp of R4 is tested on both delays alongside the settings 0, 3, 6 and 10. With a ceiling of 10, the longest wake-up bound stays within a few dozen cycles, so every boundary is reached by directed sequences.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef enum logic [1:0] {
        ACG_IDLE   = 2'd0,
        ACG_SPARE1 = 2'd1,
        ACG_GATED  = 2'd2,
        ACG_SPARE3 = 2'd3
    } acg_state_e;

    typedef struct packed {
        logic entry_run;
        logic entry_clr;
        logic exit_run;
        logic exit_clr;
    } acg_timer_ctl_t;

    function automatic int unsigned clamp_delay(input int unsigned req,
                                                input int unsigned cap);
        return (req > cap) ? cap : req;
    endfunction

endpackage

// File: rtl/acg_dwell_timer.sv
module acg_dwell_timer #(
    parameter int unsigned DLY_W   = 4,
    parameter int unsigned DLY_MAX = 10
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [DLY_W-1:0] limit_i,
    output logic             expire_o
);
    localparam int unsigned CW = $clog2(DLY_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_c;

    always_comb begin
        lim_c = CW'(acg_pkg::clamp_delay(32'(limit_i), DLY_MAX));
    end

    assign expire_o = run_i && (cnt_q >= lim_c);

    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= expire_o ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/acg_fsm.sv
module acg_fsm (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic                    busy_i,
    input  logic                    entry_hit_i,
    input  logic                    exit_hit_i,
    output acg_pkg::acg_state_e     state_q_o,
    output acg_pkg::acg_state_e     state_nxt_o,
    output acg_pkg::acg_timer_ctl_t ctl_o
);
    import acg_pkg::*;

    acg_state_e state_q;
    acg_state_e state_nxt;
    logic       armed_q;
    logic       armed_nxt;
    logic       waking;

    assign waking = (state_q == ACG_GATED) && (busy_i || armed_q);

    always_comb begin
        ctl_o.entry_run = (state_q == ACG_IDLE) && !busy_i;
        ctl_o.entry_clr = !ctl_o.entry_run;
        ctl_o.exit_run  = waking;
        ctl_o.exit_clr  = (state_q != ACG_GATED);
    end

    always_comb begin
        state_nxt = state_q;
        armed_nxt = 1'b0;
        if (!rst_n_i) begin
            state_nxt = ACG_IDLE;
        end else begin
            unique case (state_q)
                ACG_IDLE: begin
                    if (entry_hit_i) state_nxt = ACG_GATED;
                end
                ACG_GATED: begin
                    armed_nxt = waking && !exit_hit_i;
                    if (exit_hit_i) state_nxt = ACG_IDLE;
                end
                default: state_nxt = ACG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_nxt;
        armed_q <= rst_n_i ? armed_nxt : 1'b0;
    end

    assign state_q_o   = state_q;
    assign state_nxt_o = state_nxt;
endmodule

// File: rtl/acg_gate_cell.sv
module acg_gate_cell (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/act_clk_gate.sv
module act_clk_gate #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DLY_W   = 4,
    parameter int unsigned DLY_MAX = 10
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [CNT_W-1:0] txn_cnt_i,
    input  logic [DLY_W-1:0] entry_dly_i,
    input  logic [DLY_W-1:0] exit_dly_i,
    output logic             gclk_o,
    output logic [1:0]       state_o,
    output logic             clk_en_o
);
    import acg_pkg::*;

    logic           busy;
    logic           entry_hit;
    logic           exit_hit;
    acg_state_e     state_q;
    acg_state_e     state_nxt;
    acg_timer_ctl_t ctl;

    assign busy = |txn_cnt_i;

    acg_dwell_timer #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_entry (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .clr_i    (ctl.entry_clr),
        .run_i    (ctl.entry_run),
        .limit_i  (entry_dly_i),
        .expire_o (entry_hit)
    );

    acg_dwell_timer #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_exit (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .clr_i    (ctl.exit_clr),
        .run_i    (ctl.exit_run),
        .limit_i  (exit_dly_i),
        .expire_o (exit_hit)
    );

    acg_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .busy_i      (busy),
        .entry_hit_i (entry_hit),
        .exit_hit_i  (exit_hit),
        .state_q_o   (state_q),
        .state_nxt_o (state_nxt),
        .ctl_o       (ctl)
    );

    acg_gate_cell u_gate (
        .clk_i  (clk_i),
        .en_i   (state_nxt != ACG_GATED),
        .gclk_o (gclk_o)
    );

    assign state_o  = state_q;
    assign clk_en_o = (state_q != ACG_GATED);
endmodule

// File: rtl/act_clk_gate_chk.sv
module act_clk_gate_chk #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DLY_MAX = 10
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic [CNT_W-1:0] txn_cnt_i,
    input logic [1:0]       state_o,
    input logic             clk_en_o,
    input logic             gclk_o
);
    logic [7:0] wake_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i || state_o != 2'd2) begin
            wake_q <= '0;
        end else if (txn_cnt_i != '0 || wake_q != '0) begin
            wake_q <= wake_q + 8'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk_i)
        !rst_n_i |=> (state_o == 2'd0 && clk_en_o));

    p_legal_code_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_o == 2'd0 || state_o == 2'd2));

    p_busy_holds_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_o == 2'd0 && txn_cnt_i != '0) |=> state_o == 2'd0);

    p_gate_after_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(state_o == 2'd2) |-> $past(txn_cnt_i == '0));

    p_wake_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_o == 2'd2) |-> (32'(wake_q) <= DLY_MAX));

    p_gclk_low_r7: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        (state_o == 2'd2) |-> !gclk_o);

    p_gclk_runs_r8: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        (state_o == 2'd0) |-> gclk_o);
endmodule

bind act_clk_gate act_clk_gate_chk #(.CNT_W(CNT_W), .DLY_MAX(DLY_MAX)) u_chk (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .txn_cnt_i (txn_cnt_i),
    .state_o   (state_o),
    .clk_en_o  (clk_en_o),
    .gclk_o    (gclk_o)
);

// File: tb/tb_act_clk_gate.sv
`timescale 1ns/1ps
module tb_act_clk_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] txn = 8'd0;
    logic [3:0] ent = 4'd0;
    logic [3:0] ext = 4'd0;
    logic       gclk;
    logic [1:0] state;
    logic       clk_en;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    act_clk_gate dut (
        .clk_i(clk), .rst_n_i(rst_n), .txn_cnt_i(txn),
        .entry_dly_i(ent), .exit_dly_i(ext),
        .gclk_o(gclk), .state_o(state), .clk_en_o(clk_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        txn = 8'd5; ext = 4'd0;
        repeat (12) tick();
    endtask

    task automatic go_gated();
        go_idle();
        ent = 4'd0; txn = 8'd0;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; txn = 8'd0;
        repeat (3) tick();
        chk("R1", "state in reset", state, 0);
        chk("R1", "clk_en in reset", clk_en, 1);
        chk("R1", "gclk high phase in reset", gclk, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_entry(input int d, input int eff);
        go_idle();
        ent = 4'(d); txn = 8'd0;
        repeat (eff) tick();
        chk(d > 10 ? "R4" : "R3", $sformatf("still idle d=%0d", d), state, 0);
        tick();
        chk(d > 10 ? "R4" : "R3", $sformatf("gated code R2 d=%0d", d), state, 2);
        chk("R9", "clk_en when gated", clk_en, 0);
        chk("R7", "gclk in first gated cycle", gclk, 0);
    endtask

    task automatic t_entry_restart();
        go_idle();
        ent = 4'd4; txn = 8'd0;
        repeat (3) tick();
        txn = 8'd1;
        tick();
        chk("R10", "nonzero sample keeps idle", state, 0);
        txn = 8'd0;
        repeat (4) tick();
        chk("R10", "restart needs fresh samples", state, 0);
        tick();
        chk("R10", "gates after fresh window", state, 2);
    endtask

    task automatic t_exit(input int e, input int eff);
        go_gated();
        ext = 4'(e); txn = 8'd2;
        if (eff > 0) begin
            repeat (eff) tick();
            chk(e > 10 ? "R4" : "R5", $sformatf("still gated e=%0d", e), state, 2);
        end
        tick();
        chk(e > 10 ? "R4" : "R5", $sformatf("idle after wake e=%0d", e), state, 0);
        chk("R8", "gclk pulses on return", gclk, 1);
        chk("R9", "clk_en when idle", clk_en, 1);
    endtask

    task automatic t_commit();
        go_gated();
        ext = 4'd5; ent = 4'd10; txn = 8'd2;
        tick();
        txn = 8'd0;
        repeat (4) tick();
        chk("R6", "wake pending", state, 2);
        tick();
        chk("R6", "wake completes with zero count", state, 0);
    endtask

    task automatic t_hold();
        int bad = 0;
        go_gated();
        for (int i = 0; i < 20; i++) begin
            tick();
            if (state != 2 || gclk != 1'b0) bad++;
        end
        chk("R7", "gated cycles with clock or state wrong", bad, 0);
    endtask

    task automatic t_idle_clock();
        int bad = 0;
        go_idle();
        for (int i = 0; i < 10; i++) begin
            tick();
            if (gclk != 1'b1 || state != 0) bad++;
            #4;
            if (gclk != 1'b0) bad++;
        end
        chk("R8", "idle phases with wrong gclk", bad, 0);
    endtask

    task automatic t_reset_gated();
        go_gated();
        rst_n = 1'b0;
        tick();
        chk("R1", "reset from gated state", state, 0);
        chk("R1", "reset from gated gclk", gclk, 1);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_entry(0, 0);
        t_entry(3, 3);
        t_entry(10, 10);
        t_entry(15, 10);
        t_entry_restart();
        t_exit(0, 0);
        t_exit(6, 6);
        t_exit(10, 10);
        t_exit(13, 10);
        t_commit();
        t_hold();
        t_idle_clock();
        t_reset_gated();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule